// File: doc/BRIEF.md
# Sector Load Window Controller

This block gathers byte writes aimed at one 256-byte sector of a flash-style memory model and then programs that sector. Every write strobe carries an address and a data byte. The upper address bits pick the sector and the low eight bits pick the byte inside it. The first accepted write opens a load window and fixes the sector for that window. Later writes to the same sector are latched into an internal sector buffer in any order, and a per-byte loaded mask records which offsets have been written.

The window closes when no accepted write arrives for a set number of clock cycles. The block then enters a program period of fixed length. During that period it reports busy and ignores all writes. In the first 256 cycles of the period it copies the buffer into the memory array one byte per cycle. Any offset that was never loaded is written as FF. A write that names a different sector while a window is open is dropped and sets a sticky error flag. The address and data of the last accepted write stay visible on the status outputs after the period ends. Contents are read back through a registered read port with one cycle of latency.

Top module: `sector_load_ctrl`

## Requirements
- R1: Address bits ADDR_W-1..8 select the sector and bits 7..0 select the byte within it. After programming, a byte loaded at an address reads back at that same address, and programming one sector leaves the other sectors unchanged.
- R2: The window stays open as long as each accepted write is sampled within WIN_CYC rising edges of the previous accepted one. If no accepted write arrives, busy rises after exactly the WIN_CYC-th edge following the last accepted write, and loading falls at the same edge.
- R3: Bytes may be loaded in any offset order within a window, and each one is programmed at its own offset.
- R4: Every offset of the sector that was not loaded in the window reads as FF after programming.
- R5: busy stays high for exactly PROG_CYC cycles. Writes presented while busy change neither the memory contents nor last_addr/last_data, and they do not open a new window.
- R6: While a window is open, a write whose sector differs from the window's sector is ignored: it is not programmed, last_addr is unchanged, and it does not restart the timeout. It sets sect_err, which stays high until reset.
- R7: The loaded mask is cleared when a new window opens, so bytes loaded in an earlier window of the same sector read as FF unless they are loaded again.
- R8: When the program period ends, busy is low and last_addr/last_data still hold the address and data of the last accepted write.
- R9: After reset, busy, loading and sect_err are 0 and last_addr/last_data are 0.
- R10: When the same offset is written more than once in a window, the last value is the one programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Write address: sector in upper bits, offset in bits 7..0 |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte at rd_addr, registered |
| busy | output | 1 | High during the program period |
| loading | output | 1 | High while a load window is open |
| sect_err | output | 1 | Sticky flag for a write to the wrong sector |
| last_addr | output | ADDR_W | Address of the last accepted write |
| last_data | output | 8 | Data of the last accepted write |

## Verification
The properties assume that wr_en, wr_addr and wr_data change only between clock edges and hold for a whole cycle. They also assume that reset is applied before the first write and that PROG_CYC is at least 256, so that the commit walk fits inside the program period. The stimulus drives every input on the falling edge and presents one write per cycle at most. It shortens both intervals through parameters so that whole windows, including a write sampled one edge before timeout, fit easily in a run. Stray-sector writes and writes during the program period are placed deliberately, so that the claims about dropped writes are checked by reading whole sectors back through the normal read port.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 8;
    localparam int SECT_BYTES = 1 << OFS_W;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    // one byte moving into the buffer or out of it toward the array
    typedef struct packed {
        logic  valid;
        ofs_t  ofs;
        byte_t data;
    } beat_t;

    function automatic byte_t fill_byte(input logic loaded, input byte_t val);
        return loaded ? val : ERASED_BYTE;
    endfunction
endpackage

// File: rtl/slc_fsm.sv
module slc_fsm
    import slc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  byte_t                   wr_data,
    output phase_e                  phase,
    output logic                    buf_open,
    output beat_t                   buf_wr,
    output logic                    commit_go,
    output ofs_t                    commit_ofs,
    output logic [ADDR_W-OFS_W-1:0] sect_q,
    output logic                    err,
    output logic [ADDR_W-1:0]       last_addr,
    output byte_t                   last_data
);
    localparam int WIN_W     = $clog2(WIN_CYC + 1);
    localparam int PROG_SPAN = (PROG_CYC > SECT_BYTES) ? PROG_CYC : SECT_BYTES;
    localparam int PROG_W    = $clog2(PROG_SPAN + 1);

    logic [WIN_W-1:0]  idle_cnt;
    logic [PROG_W-1:0] prog_cnt;
    logic              sect_hit;
    logic              first_wr;
    logic              more_wr;
    logic              stray_wr;

    always_comb begin
        sect_hit = (wr_addr[ADDR_W-1:OFS_W] == sect_q);
        first_wr = (phase == PH_IDLE) && wr_en;
        more_wr  = (phase == PH_LOAD) && wr_en && sect_hit;
        stray_wr = (phase == PH_LOAD) && wr_en && !sect_hit;
    end

    assign buf_open   = first_wr;
    assign buf_wr     = '{valid: first_wr | more_wr,
                          ofs:   wr_addr[OFS_W-1:0],
                          data:  wr_data};
    assign commit_go  = (phase == PH_PROG) && (prog_cnt < PROG_W'(SECT_BYTES));
    assign commit_ofs = prog_cnt[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            sect_q    <= '0;
            idle_cnt  <= '0;
            prog_cnt  <= '0;
            err       <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (stray_wr) begin
                err <= 1'b1;
            end
            if (first_wr || more_wr) begin
                last_addr <= wr_addr;
                last_data <= wr_data;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (first_wr) begin
                        sect_q   <= wr_addr[ADDR_W-1:OFS_W];
                        idle_cnt <= '0;
                        phase    <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (more_wr) begin
                        idle_cnt <= '0;
                    end else if (idle_cnt == WIN_W'(WIN_CYC - 1)) begin
                        prog_cnt <= '0;
                        phase    <= PH_PROG;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (prog_cnt == PROG_W'(PROG_CYC - 1)) begin
                        phase <= PH_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slc_sector_buf.sv
module slc_sector_buf
    import slc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  open,
    input  beat_t wr,
    input  logic  commit_go,
    input  ofs_t  commit_ofs,
    output beat_t commit
);
    byte_t                 bytes_q [SECT_BYTES];
    logic [SECT_BYTES-1:0] loaded_q;
    logic [SECT_BYTES-1:0] loaded_nxt;

    for (genvar i = 0; i < SECT_BYTES; i++) begin : g_mask
        logic hit;
        assign hit           = wr.valid && (wr.ofs == OFS_W'(i));
        assign loaded_nxt[i] = open ? hit : (loaded_q[i] | hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded_q <= '0;
        end else begin
            loaded_q <= loaded_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.valid) begin
            bytes_q[wr.ofs] <= wr.data;
        end
    end

    assign commit = '{valid: commit_go,
                      ofs:   commit_ofs,
                      data:  fill_byte(loaded_q[commit_ofs], bytes_q[commit_ofs])};
endmodule

// File: rtl/slc_array.sv
module slc_array
    import slc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/sector_load_ctrl.sv
module sector_load_ctrl
    import slc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              loading,
    output logic              sect_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [7:0]        last_data
);
    localparam int SECT_W = ADDR_W - OFS_W;

    phase_e            phase;
    logic              buf_open;
    beat_t             buf_wr;
    logic              commit_go;
    ofs_t              commit_ofs;
    beat_t             commit;
    logic [SECT_W-1:0] sect_cur;

    slc_fsm #(
        .ADDR_W  (ADDR_W),
        .WIN_CYC (WIN_CYC),
        .PROG_CYC(PROG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .phase     (phase),
        .buf_open  (buf_open),
        .buf_wr    (buf_wr),
        .commit_go (commit_go),
        .commit_ofs(commit_ofs),
        .sect_q    (sect_cur),
        .err       (sect_err),
        .last_addr (last_addr),
        .last_data (last_data)
    );

    slc_sector_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .open      (buf_open),
        .wr        (buf_wr),
        .commit_go (commit_go),
        .commit_ofs(commit_ofs),
        .commit    (commit)
    );

    slc_array #(
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .we   (commit.valid),
        .waddr({sect_cur, commit.ofs}),
        .wdata(commit.data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    assign busy    = (phase == PH_PROG);
    assign loading = (phase == PH_LOAD);
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int ADDR_W   = 11,
    parameter int PROG_CYC = 500000
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              loading,
    input logic              sect_err,
    input logic [ADDR_W-1:0] last_addr,
    input logic [7:0]        last_data,
    input logic [ADDR_W-9:0] sect_q
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_run + 1;
        end
    end

    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !loading && !sect_err && last_addr == '0));

    a_r2_close_to_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(loading) |-> busy);

    a_r2_hit_keeps_open: assert property (@(posedge clk) disable iff (rst)
        (loading && wr_en && wr_addr[ADDR_W-1:8] == sect_q) |=> loading);

    a_r5_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, loading}));

    a_r5_busy_ignores_wr: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < PROG_CYC));

    a_r6_stray_flags: assert property (@(posedge clk) disable iff (rst)
        (loading && wr_en && wr_addr[ADDR_W-1:8] != sect_q) |=> (sect_err && $stable(last_addr)));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        sect_err |=> sect_err);

    a_r8_status_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($stable(last_addr) && $stable(last_data) && !loading));
endmodule

bind sector_load_ctrl slc_checker #(
    .ADDR_W  (ADDR_W),
    .PROG_CYC(PROG_CYC)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .busy     (busy),
    .loading  (loading),
    .sect_err (sect_err),
    .last_addr(last_addr),
    .last_data(last_data),
    .sect_q   (sect_cur)
);

// File: tb/test_sector_load_ctrl.sv
module test_sector_load_ctrl;
    localparam int AW     = 11;
    localparam int WIN    = 20;
    localparam int PROG   = 300;
    localparam int NBYTES = 1 << AW;
    localparam int WDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          loading;
    logic          sect_err;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;

    sector_load_ctrl #(
        .ADDR_W  (AW),
        .WIN_CYC (WIN),
        .PROG_CYC(PROG)
    ) i_sector_load_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .loading  (loading),
        .sect_err (sect_err),
        .last_addr(last_addr),
        .last_data(last_data)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            due;
        logic [AW-1:0] addr;
        logic [7:0]    exp;
        string         tag;
    } rd_item_t;

    rd_item_t   exp_q[$];
    rd_item_t   cur;
    logic [7:0] model [NBYTES];
    logic [7:0] win_buf [256];
    bit         win_mask [256];
    int         win_sect;

    task automatic check(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // scoreboard monitor: pops each read once its registered data is out
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            cur = exp_q.pop_front();
            total++;
            if (rd_data !== cur.exp) begin
                bad++;
                $display("FAIL %s read addr %0h: got %0h expected %0h",
                         cur.tag, cur.addr, rd_data, cur.exp);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == WDOG) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raw_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic open_win(input int sect);
        win_sect = sect;
        for (int i = 0; i < 256; i++) win_mask[i] = 1'b0;
    endtask

    task automatic load(input int ofs, input logic [7:0] d);
        raw_wr(AW'((win_sect << 8) | ofs), d);
        win_buf[ofs]  = d;
        win_mask[ofs] = 1'b1;
    endtask

    task automatic rd(input int a, input logic [7:0] e, input string tag);
        rd_item_t it;
        rd_addr = AW'(a);
        it.due  = cyc + 1;
        it.addr = AW'(a);
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wait_prog_done();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = 0; i < 256; i++)
            model[(win_sect << 8) | i] = win_mask[i] ? win_buf[i] : 8'hFF;
    endtask

    task automatic check_sector(input int sect, input string tag);
        for (int i = 0; i < 256; i++) rd((sect << 8) | i, model[(sect << 8) | i], tag);
        idle(2);
    endtask

    initial begin
        int n;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R9: state after reset
        check("R9", "busy", busy, 0);
        check("R9", "loading", loading, 0);
        check("R9", "sect_err", sect_err, 0);
        check("R9", "last_addr", last_addr, 0);
        check("R9", "last_data", last_data, 0);

        // R3 / R2 / R5 / R8 / R4: sector 2, scrambled order
        open_win(2);
        load(200, 8'h3C);
        load(5, 8'hA5);
        load(3, 8'h11);
        check("R2", "loading after open", loading, 1);
        idle(WIN - 1);
        check("R2", "busy one edge before timeout", busy, 0);
        check("R2", "loading one edge before timeout", loading, 1);
        idle(1);
        check("R2", "busy at timeout", busy, 1);
        check("R2", "loading at timeout", loading, 0);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check("R5", "busy length", n, PROG);
        check("R8", "busy after program", busy, 0);
        check("R8", "last_addr", last_addr, (2 << 8) | 3);
        check("R8", "last_data", last_data, 8'h11);
        for (int i = 0; i < 256; i++)
            model[(2 << 8) | i] = win_mask[i] ? win_buf[i] : 8'hFF;
        check_sector(2, "R4");
        rd((2 << 8) | 200, 8'h3C, "R3");

        // R2 extension, R6 stray sector, R10 overwrite: sector 1
        open_win(1);
        load(0, 8'h01);
        idle(WIN - 2);
        load(255, 8'h7E);
        check("R2", "window kept by late write", loading, 1);
        check("R2", "no busy after late write", busy, 0);
        idle(3);
        raw_wr(AW'((5 << 8) | 40), 8'h99);
        check("R6", "sect_err set", sect_err, 1);
        check("R6", "last_addr after stray", last_addr, (1 << 8) | 255);
        load(10, 8'h55);
        load(10, 8'h66);
        wait_prog_done();
        check("R10", "last_data", last_data, 8'h66);
        check("R6", "sect_err sticky", sect_err, 1);
        check_sector(1, "R10");
        rd((1 << 8) | 40, 8'hFF, "R6");
        rd((1 << 8) | 10, 8'h66, "R10");

        // R7 mask cleared, R5 writes ignored while busy, R1 isolation
        open_win(2);
        load(10, 8'hC3);
        while (!busy) @(negedge clk);
        raw_wr(AW'((2 << 8) | 5), 8'hEE);
        raw_wr(AW'((3 << 8) | 0), 8'h44);
        check("R5", "last_addr during busy", last_addr, (2 << 8) | 10);
        check("R5", "last_data during busy", last_data, 8'hC3);
        wait_prog_done();
        idle(1);
        check("R5", "no window opened by busy write", loading, 0);
        check_sector(2, "R7");
        rd((2 << 8) | 5, 8'hFF, "R5");
        rd((2 << 8) | 200, 8'hFF, "R7");
        check_sector(1, "R1");

        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule